// File: doc/BRIEF.md
# Output Command Buffer Copy Controller

This block stands between processor-visible output command registers and the active output buffers that a serial transmit engine drives onto its channels. Each of four channels has a processor-writable command word and an active copy. The transmit engine reads the active copy, so that copy must never change while a transfer on that channel is running.

Each channel has a copy mode. In immediate mode a fresh write reaches the active buffer as soon as the channel is idle. In vblank mode the write is parked and moves across only on a vertical-blank pulse. Vblank mode lets software line a command up with a video frame, for example to time liquid-crystal shutter glasses. A separate force request copies every channel's parked word at once. Its bit reads back as a pending flag until every channel has been served.

Top module: `obuf_copy_ctrl`

## Requirements
- R1: During and after reset every active buffer is zero, `copy_pending` is 0 and every channel is in immediate mode.
- R2: A write on the mode port loads the copy mode of all channels: bit c of `mode_wr_data` is channel c's mode, where 0 means immediate and 1 means vblank. A write to one channel's bit leaves the other channels' modes unchanged in effect.
- R3: In immediate mode, a command write to an idle channel appears on that channel's active buffer in the cycle after the write is taken.
- R4: In immediate mode, a command write to a busy channel is parked. It is copied at the first clock edge where that channel's `xfer_busy` is low, so it is visible in the cycle after busy falls.
- R5: In vblank mode, a command write does not change the active buffer. The parked word is copied at a clock edge where `vblank` is high and the channel is idle. A vblank that arrives while the channel is busy leaves the word parked for a later vblank.
- R6: A second command write to a channel before its parked word is copied replaces the parked word. Only the later value reaches the active buffer.
- R7: A control write with `ctl_wr_force` = 1 (bit 31 of the control word) raises `copy_pending` in the next cycle. A control write with the bit at 0 has no effect.
- R8: While the force request is outstanding, each idle channel copies its parked word at the next clock edge. `copy_pending` returns to 0 once every channel has been copied. Busy channels are served when they go idle.
- R9: While `xfer_busy[c]` is high, the active buffer of channel c does not change, whatever the mode, vblank or force request.
- R10: A command write to one channel changes no other channel's active buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command word write strobe |
| cmd_wr_sel | input | SW | Channel addressed by the command write |
| cmd_wr_data | input | DW | Command word written |
| mode_wr_en | input | 1 | Copy-mode field write strobe |
| mode_wr_data | input | NCH | Copy-mode bits, one per channel (1 = vblank) |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_force | input | 1 | Bit 31 of the control word: 1 requests a copy of all buffers |
| xfer_busy | input | NCH | Transfer in progress, one bit per channel |
| vblank | input | 1 | Vertical-blank pulse |
| active_buf | output | NCH*DW | Active output buffers, channel c in bits [c*DW +: DW] |
| copy_pending | output | 1 | Read-back of the force bit: 1 until all buffers are copied |

## Verification
A parked word that is lost or corrupted shows up on `active_buf` at the first copy opportunity, which is the next idle edge, the next vblank or the next forced copy. The symptom is a value that differs from the last word written. A stale per-channel force flag shows on `copy_pending`, which stays high one cycle after all channels are idle. A lost flag drops `copy_pending` early or leaves a buffer uncopied. A wrong latched mode is caught by the first write after the mode change, because the buffer is then updated either one cycle too soon or not until a vblank.

// File: rtl/obuf_pkg.sv
package obuf_pkg;

    typedef enum logic {
        CPY_NOW = 1'b0,
        CPY_VBL = 1'b1
    } cpy_mode_e;

    // per-slot copy controls gathered for one clock edge
    typedef struct packed {
        logic      wr_hit;
        logic      busy;
        logic      vblank;
        logic      force_due;
        cpy_mode_e mode;
    } slot_ctl_t;

    // decides whether a slot moves its parked word at this edge
    function automatic logic slot_fires(input slot_ctl_t c, input logic pend_q);
        if (c.busy)
            return 1'b0;
        if (c.force_due)
            return 1'b1;
        return (pend_q | c.wr_hit) & ((c.mode == CPY_NOW) | c.vblank);
    endfunction

endpackage

// File: rtl/obuf_mode_reg.sv
module obuf_mode_reg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] mode_o
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_o <= '0;
        else if (wr_en)
            mode_o <= wr_data;
    end

endmodule

// File: rtl/obuf_force_ctl.sv
module obuf_force_ctl #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           req,
    input  logic [NCH-1:0] busy,
    output logic [NCH-1:0] due_o,
    output logic           pending_o
);

    logic [NCH-1:0] due_n;

    // an idle channel is served at the edge it sees its flag
    always_comb begin
        if (req)
            due_n = '1;
        else
            due_n = due_o & busy;
    end

    always_ff @(posedge clk) begin
        if (rst)
            due_o <= '0;
        else
            due_o <= due_n;
    end

    assign pending_o = |due_o;

endmodule

// File: rtl/obuf_chan_slot.sv
module obuf_chan_slot
    import obuf_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  slot_ctl_t     ctl,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] active_o
);

    logic [DW-1:0] held_q;
    logic [DW-1:0] held_n;
    logic          pend_q;
    logic          fire;

    always_comb begin
        held_n = ctl.wr_hit ? wr_data : held_q;
        fire   = slot_fires(ctl, pend_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            pend_q   <= 1'b0;
            active_o <= '0;
        end else begin
            held_q <= held_n;
            if (fire) begin
                active_o <= held_n;
                pend_q   <= 1'b0;
            end else begin
                pend_q <= pend_q | ctl.wr_hit;
            end
        end
    end

endmodule

// File: rtl/obuf_copy_ctrl.sv
module obuf_copy_ctrl
    import obuf_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 32,
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr_en,
    input  logic [SW-1:0]     cmd_wr_sel,
    input  logic [DW-1:0]     cmd_wr_data,
    input  logic              mode_wr_en,
    input  logic [NCH-1:0]    mode_wr_data,
    input  logic              ctl_wr_en,
    input  logic              ctl_wr_force,
    input  logic [NCH-1:0]    xfer_busy,
    input  logic              vblank,
    output logic [NCH*DW-1:0] active_buf,
    output logic              copy_pending
);

    logic [NCH-1:0] mode_q;
    logic [NCH-1:0] force_due;
    logic           force_req;

    assign force_req = ctl_wr_en & ctl_wr_force;

    obuf_mode_reg #(.NCH(NCH)) u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_en),
        .wr_data (mode_wr_data),
        .mode_o  (mode_q)
    );

    obuf_force_ctl #(.NCH(NCH)) u_force (
        .clk       (clk),
        .rst       (rst),
        .req       (force_req),
        .busy      (xfer_busy),
        .due_o     (force_due),
        .pending_o (copy_pending)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_slot
        slot_ctl_t ctl;

        always_comb begin
            ctl.wr_hit    = cmd_wr_en & (cmd_wr_sel == SW'(c));
            ctl.busy      = xfer_busy[c];
            ctl.vblank    = vblank;
            ctl.force_due = force_due[c];
            ctl.mode      = cpy_mode_e'(mode_q[c]);
        end

        obuf_chan_slot #(.DW(DW)) u_slot (
            .clk      (clk),
            .rst      (rst),
            .ctl      (ctl),
            .wr_data  (cmd_wr_data),
            .active_o (active_buf[c*DW +: DW])
        );
    end

endmodule

// File: rtl/obuf_copy_ctrl_chk.sv
module obuf_copy_ctrl_chk #(
    parameter int NCH = 4,
    parameter int DW  = 32,
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_wr_en,
    input logic [SW-1:0]     cmd_wr_sel,
    input logic [DW-1:0]     cmd_wr_data,
    input logic              ctl_wr_en,
    input logic              ctl_wr_force,
    input logic [NCH-1:0]    xfer_busy,
    input logic              vblank,
    input logic [NCH*DW-1:0] active_buf,
    input logic              copy_pending,
    input logic [NCH-1:0]    mode_q
);

    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_seen) begin
            reset_state_chk: assert (active_buf == '0 && !copy_pending && mode_q == '0)
                else $error("reset state wrong");
        end
    end

    // R7
    force_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr_en && ctl_wr_force) |=> copy_pending);

    // R7
    force_noop_chk: assert property (@(posedge clk) disable iff (rst)
        (!copy_pending && !(ctl_wr_en && ctl_wr_force)) |=> !copy_pending);

    // R8
    force_done_chk: assert property (@(posedge clk) disable iff (rst)
        (copy_pending && xfer_busy == '0 && !(ctl_wr_en && ctl_wr_force)) |=> !copy_pending);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R9
        busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
            xfer_busy[c] |=> $stable(active_buf[c*DW +: DW]));

        // R3
        imm_copy_chk: assert property (@(posedge clk) disable iff (rst)
            (cmd_wr_en && cmd_wr_sel == SW'(c) && !mode_q[c] && !xfer_busy[c])
            |=> active_buf[c*DW +: DW] == $past(cmd_wr_data));

        // R5
        vbl_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_q[c] && !vblank && !copy_pending) |=> $stable(active_buf[c*DW +: DW]));
    end

endmodule

bind obuf_copy_ctrl obuf_copy_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_wr_en    (cmd_wr_en),
    .cmd_wr_sel   (cmd_wr_sel),
    .cmd_wr_data  (cmd_wr_data),
    .ctl_wr_en    (ctl_wr_en),
    .ctl_wr_force (ctl_wr_force),
    .xfer_busy    (xfer_busy),
    .vblank       (vblank),
    .active_buf   (active_buf),
    .copy_pending (copy_pending),
    .mode_q       (mode_q)
);

// File: tb/obuf_copy_ctrl_tb.sv
`timescale 1ns/1ps
module obuf_copy_ctrl_tb;
    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int SW  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_wr_en = 1'b0;
    logic [SW-1:0]     cmd_wr_sel = '0;
    logic [DW-1:0]     cmd_wr_data = '0;
    logic              mode_wr_en = 1'b0;
    logic [NCH-1:0]    mode_wr_data = '0;
    logic              ctl_wr_en = 1'b0;
    logic              ctl_wr_force = 1'b0;
    logic [NCH-1:0]    xfer_busy = '0;
    logic              vblank = 1'b0;
    logic [NCH*DW-1:0] active_buf;
    logic              copy_pending;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    obuf_copy_ctrl #(.NCH(NCH), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .cmd_wr_en(cmd_wr_en), .cmd_wr_sel(cmd_wr_sel), .cmd_wr_data(cmd_wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_force(ctl_wr_force),
        .xfer_busy(xfer_busy), .vblank(vblank),
        .active_buf(active_buf), .copy_pending(copy_pending)
    );

    // behavioural reference: per-channel parked word, parked flag, force flag
    logic [DW-1:0] m_act  [NCH];
    logic [DW-1:0] m_park [NCH];
    bit            m_has  [NCH];
    bit            m_frc  [NCH];
    bit            m_vbl  [NCH];

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_act[c] = '0; m_park[c] = '0; m_has[c] = 0; m_frc[c] = 0; m_vbl[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit hit;
                bit copy_now;
                hit = cmd_wr_en && (int'(cmd_wr_sel) == c);
                if (hit) begin
                    m_park[c] = cmd_wr_data;
                    m_has[c]  = 1;
                end
                copy_now = !xfer_busy[c] &&
                           (m_frc[c] || (m_has[c] && (!m_vbl[c] || vblank)));
                if (copy_now) begin
                    m_act[c] = m_park[c];
                    m_has[c] = 0;
                end
                if (ctl_wr_en && ctl_wr_force) m_frc[c] = 1;
                else if (!xfer_busy[c])        m_frc[c] = 0;
            end
            if (mode_wr_en)
                for (int c = 0; c < NCH; c++) m_vbl[c] = mode_wr_data[c];
        end
    end

    function automatic bit m_pending();
        bit p = 0;
        for (int c = 0; c < NCH; c++) p |= m_frc[c];
        return p;
    endfunction

    // compared on every clock, after the edge settles
    always @(posedge clk) begin
        #3;
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                total++;
                if (active_buf[c*DW +: DW] !== m_act[c]) begin
                    bad++;
                    $display("FAIL R3-model ch%0d active actual=%h expected=%h (R4 R5 R6 R8 R9)",
                             c, active_buf[c*DW +: DW], m_act[c]);
                end
            end
            total++;
            if (copy_pending !== m_pending()) begin
                bad++;
                $display("FAIL R7 copy_pending actual=%0b expected=%0b (R8)",
                         copy_pending, m_pending());
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] ab(input int c);
        return active_buf[c*DW +: DW];
    endfunction

    task automatic wr_cmd(input int c, input logic [DW-1:0] d);
        cmd_wr_en = 1'b1; cmd_wr_sel = SW'(c); cmd_wr_data = d;
        tick();
        cmd_wr_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) tick();
        // R1: outputs held clear during reset
        chk("R1 active during reset", active_buf[DW-1:0], '0);
        rst = 1'b0;
        tick();
        for (int c = 0; c < NCH; c++) chk("R1 active after reset", ab(c), '0);
        chk("R1 pending after reset", {31'd0, copy_pending}, '0);

        // R3: immediate copy, R10: other channels untouched
        wr_cmd(1, 32'hA1A1_0001);
        chk("R3 immediate copy ch1", ab(1), 32'hA1A1_0001);
        chk("R10 ch0 untouched", ab(0), '0);
        chk("R10 ch2 untouched", ab(2), '0);

        // R4: write during busy is parked, copied after busy falls
        xfer_busy[2] = 1'b1;
        wr_cmd(2, 32'hB2B2_0002);
        chk("R4 parked while busy", ab(2), '0);
        tick();
        chk("R9 busy channel held", ab(2), '0);
        xfer_busy[2] = 1'b0;
        tick();
        chk("R4 copied after busy", ab(2), 32'hB2B2_0002);

        // R6: later write overwrites parked word
        xfer_busy[3] = 1'b1;
        wr_cmd(3, 32'hC3C3_0001);
        wr_cmd(3, 32'hC3C3_0002);
        xfer_busy[3] = 1'b0;
        tick();
        chk("R6 later value copied", ab(3), 32'hC3C3_0002);

        // R2: mode bit 0 -> vblank for ch0 only
        mode_wr_en = 1'b1; mode_wr_data = 4'b0001;
        tick();
        mode_wr_en = 1'b0;
        wr_cmd(0, 32'hD0D0_0000);
        tick();
        chk("R5 vblank mode holds", ab(0), '0);
        wr_cmd(1, 32'hE1E1_0001);
        chk("R2 ch1 still immediate", ab(1), 32'hE1E1_0001);
        // R5: vblank while busy does not copy
        xfer_busy[0] = 1'b1; vblank = 1'b1;
        tick();
        vblank = 1'b0; xfer_busy[0] = 1'b0;
        tick();
        chk("R5 vblank while busy ignored", ab(0), '0);
        vblank = 1'b1;
        tick();
        vblank = 1'b0;
        chk("R5 vblank copy", ab(0), 32'hD0D0_0000);

        // R7: force bit 0 does nothing
        wr_cmd(0, 32'hF0F0_0000);
        ctl_wr_en = 1'b1; ctl_wr_force = 1'b0;
        tick();
        ctl_wr_en = 1'b0;
        chk("R7 write 0 no pending", {31'd0, copy_pending}, '0);
        tick();
        chk("R7 write 0 no copy", ab(0), 32'hD0D0_0000);

        // R8: forced copy, busy channel waits
        xfer_busy[1] = 1'b1;
        ctl_wr_en = 1'b1; ctl_wr_force = 1'b1;
        tick();
        ctl_wr_en = 1'b0; ctl_wr_force = 1'b0;
        chk("R7 pending raised", {31'd0, copy_pending}, 32'd1);
        tick();
        chk("R8 forced copy ch0", ab(0), 32'hF0F0_0000);
        chk("R8 pending while ch1 busy", {31'd0, copy_pending}, 32'd1);
        xfer_busy[1] = 1'b0;
        tick();
        chk("R8 pending cleared", {31'd0, copy_pending}, '0);

        // mixed stimulus, reference model compares each clock
        for (int i = 0; i < 4000; i++) begin
            cmd_wr_en    = ($urandom % 3) == 0;
            cmd_wr_sel   = SW'($urandom);
            cmd_wr_data  = $urandom;
            vblank       = ($urandom % 16) == 0;
            mode_wr_en   = ($urandom % 40) == 0;
            mode_wr_data = NCH'($urandom);
            ctl_wr_en    = ($urandom % 30) == 0;
            ctl_wr_force = $urandom % 2;
            for (int c = 0; c < NCH; c++)
                if (($urandom % 8) == 0) xfer_busy[c] = ~xfer_busy[c];
            tick();
        end
        cmd_wr_en = 0; mode_wr_en = 0; ctl_wr_en = 0; vblank = 0; xfer_busy = '0;
        repeat (3) tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog (R1..all) actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule